// File: doc/BRIEF.md
# Serial Flash Command Gate and Write Protection

This block decides, for every instruction frame a serial NOR flash slave receives, whether the instruction is carried out or dropped. A byte deserializer in front of it runs in SPI mode 0. When chip select rises it presents one frame: the opcode, the address, the number of serial clock edges counted while select was low, the first data byte and the level of the write-protect pin. The block holds the write-enable latch, the two block-protect bits and the status-lock bit. It also tracks a power-up wait, an operation in progress and deep power-down.

One clock after each frame, exactly one of two pulses appears: accept or reject. An accepted program, sector erase, bulk erase or status write starts an internal busy timer that stands in for the real program/erase engine. When that timer finishes, the operation is complete and the write-enable latch clears. The status byte is always visible on an output.

The control state machine has four states. `ST_PWRUP` is entered at reset and left for `ST_IDLE` when the power-up timer expires. `ST_IDLE` goes to `ST_BUSY` on an accepted modifying instruction, and to `ST_DEEP` on an accepted power-down instruction. `ST_BUSY` returns to `ST_IDLE` when the busy timer completes. `ST_DEEP` returns to `ST_IDLE` on the release instruction.

Top module: `flash_wp_ctrl`

## Requirements
- R1: In idle or power-up, opcode 06h is accepted and sets the write-enable latch (status bit 1), and opcode 04h is accepted and clears it.
- R2: A program (02h), sector erase (D8h), bulk erase (C7h) or status write (01h) that arrives with the write-enable latch clear is rejected.
- R3: An accepted modifying instruction raises the in-progress bit (status bit 0) for BUSY_CYCLES clocks. When that bit drops, the write-enable latch reads 0.
- R4: A modifying instruction whose clock-edge count is zero or not a multiple of eight is rejected, and the write-enable latch keeps its value.
- R5: The block-protect field is status bits 3:2. The sector is the top two address bits. Field value 01 locks sector 3, 10 locks sectors 2 and 3, and 11 locks all sectors. Program or erase aimed at a locked sector is rejected, and bulk erase is rejected whenever the field is nonzero.
- R6: A status write takes bits 3:2 and bit 7 of the data byte into the protect field and the lock bit (status bit 7). It is rejected while the lock bit is 1 and wp_n is low.
- R7: After an accepted B9h, deep_pd is 1 and every opcode except ABh is rejected, with no effect on the status byte. ABh is accepted and clears deep_pd.
- R8: For PUW_CYCLES clocks after reset, every modifying instruction is rejected, even with the write-enable latch set.
- R9: While the in-progress bit is 1, only the status read (05h) is accepted.
- R10: After reset the status byte reads 00h (with default reset parameters), and cmd_ok, cmd_bad and deep_pd are 0.
- R11: Each frame_valid pulse produces exactly one of cmd_ok or cmd_bad in the next cycle, and neither pulse appears otherwise. Unknown opcodes are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| frame_valid | input | 1 | One-cycle pulse: a frame has ended (chip select rose) |
| frame_opcode | input | 8 | Instruction byte of the frame |
| frame_addr | input | ADDR_W | Byte address of the frame |
| frame_bits | input | CNT_W | Serial clock edges counted while select was low |
| frame_data | input | 8 | First data byte (new status value for 01h) |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_ok | output | 1 | Pulse: previous frame accepted |
| cmd_bad | output | 1 | Pulse: previous frame rejected |
| deep_pd | output | 1 | Deep power-down active |
| status_o | output | 8 | Status byte {lock, 000, protect[1:0], wel, wip} |

## Verification
The bench builds the block with PUW_CYCLES of 40 and BUSY_CYCLES of 8. Both the power-up lockout and the end of each operation therefore arrive within a few dozen clocks, so the latch clearing on completion can be observed after every accepted write. The 18-bit address keeps the default four-sector map, which lets each block-protect code be tested against sectors both inside and outside the locked range.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [1:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_BUSY,
        ST_DEEP
    } wp_state_e;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'hD8;
    localparam logic [7:0] OP_BE   = 8'hC7;
    localparam logic [7:0] OP_DP   = 8'hB9;
    localparam logic [7:0] OP_RES  = 8'hAB;

    function automatic logic is_modify(input logic [7:0] op);
        return (op == OP_PP) || (op == OP_SE) || (op == OP_BE) || (op == OP_WRSR);
    endfunction

endpackage

// File: rtl/flash_wp_timer.sv
module flash_wp_timer #(
    parameter int CYCLES       = 16,
    parameter bit START_LOADED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LOAD = W'(CYCLES);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= START_LOADED ? LOAD : '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == W'(1));

endmodule

// File: rtl/flash_wp_region.sv
module flash_wp_region #(
    parameter int ADDR_W = 18
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              addr_locked,
    output logic              any_lock
);
    localparam int SEC_LSB = ADDR_W - 2;

    logic [1:0] sector;

    always_comb begin
        sector = addr[ADDR_W-1:SEC_LSB];
        unique case (bp)
            2'b00: addr_locked = 1'b0;
            2'b01: addr_locked = (sector == 2'b11);
            2'b10: addr_locked = sector[1];
            2'b11: addr_locked = 1'b1;
        endcase
        any_lock = |bp;
    end

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int         ADDR_W      = 18,
    parameter int         CNT_W       = 12,
    parameter int         PUW_CYCLES  = 100000,
    parameter int         BUSY_CYCLES = 5000,
    parameter logic [1:0] BP_RST      = 2'b00,
    parameter logic       SRWD_RST    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [7:0]        frame_opcode,
    input  logic [ADDR_W-1:0] frame_addr,
    input  logic [CNT_W-1:0]  frame_bits,
    input  logic [7:0]        frame_data,
    input  logic              wp_n,
    output logic              cmd_ok,
    output logic              cmd_bad,
    output logic              deep_pd,
    output logic [7:0]        status_o
);
    wp_state_e  state, nxt;
    logic       wel, srwd;
    logic [1:0] bp;
    logic       puw_done, busy_done;
    logic       addr_locked, any_lock;
    logic       acc, go_busy, wel_set, wel_clr, sr_wr;
    logic       aligned, hw_lock;

    flash_wp_timer #(.CYCLES(PUW_CYCLES), .START_LOADED(1'b1)) puw_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(1'b0), .done(puw_done)
    );

    flash_wp_timer #(.CYCLES(BUSY_CYCLES), .START_LOADED(1'b0)) busy_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(go_busy), .done(busy_done)
    );

    flash_wp_region #(.ADDR_W(ADDR_W)) region_i (
        .bp(bp), .addr(frame_addr), .addr_locked(addr_locked), .any_lock(any_lock)
    );

    assign aligned = (frame_bits[2:0] == 3'b000) && (frame_bits != '0);
    assign hw_lock = srwd && !wp_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= nxt;
    end

    // Decision and next state
    always_comb begin
        nxt     = state;
        acc     = 1'b0;
        go_busy = 1'b0;
        wel_set = 1'b0;
        wel_clr = 1'b0;
        sr_wr   = 1'b0;
        if (frame_valid) begin
            unique case (state)
                ST_PWRUP: begin
                    if (frame_opcode == OP_WREN) begin
                        acc = 1'b1; wel_set = 1'b1;
                    end else if (frame_opcode == OP_WRDI) begin
                        acc = 1'b1; wel_clr = 1'b1;
                    end else if (frame_opcode == OP_RDSR) begin
                        acc = 1'b1;
                    end
                end
                ST_IDLE: begin
                    case (frame_opcode)
                        OP_WREN: begin acc = 1'b1; wel_set = 1'b1; end
                        OP_WRDI: begin acc = 1'b1; wel_clr = 1'b1; end
                        OP_RDSR, OP_RES: acc = 1'b1;
                        OP_DP:   begin acc = 1'b1; nxt = ST_DEEP; end
                        OP_WRSR: acc = wel && aligned && !hw_lock;
                        OP_PP, OP_SE: acc = wel && aligned && !addr_locked;
                        OP_BE:   acc = wel && aligned && !any_lock;
                        default: acc = 1'b0;
                    endcase
                    if (acc && is_modify(frame_opcode)) begin
                        go_busy = 1'b1;
                        nxt     = ST_BUSY;
                        sr_wr   = (frame_opcode == OP_WRSR);
                    end
                end
                ST_BUSY: acc = (frame_opcode == OP_RDSR);
                ST_DEEP: begin
                    if (frame_opcode == OP_RES) begin
                        acc = 1'b1; nxt = ST_IDLE;
                    end
                end
            endcase
        end
        if (state == ST_PWRUP && puw_done) nxt = ST_IDLE;
        if (state == ST_BUSY && busy_done) begin
            nxt     = ST_IDLE;
            wel_clr = 1'b1;
        end
    end

    // Registered outputs and status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_ok  <= 1'b0;
            cmd_bad <= 1'b0;
            wel     <= 1'b0;
            bp      <= BP_RST;
            srwd    <= SRWD_RST;
        end else begin
            cmd_ok  <= frame_valid && acc;
            cmd_bad <= frame_valid && !acc;
            if (wel_clr)      wel <= 1'b0;
            else if (wel_set) wel <= 1'b1;
            if (sr_wr) begin
                bp   <= frame_data[3:2];
                srwd <= frame_data[7];
            end
        end
    end

    assign deep_pd  = (state == ST_DEEP);
    assign status_o = {srwd, 3'b000, bp, wel, (state == ST_BUSY)};

endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk
    import flash_wp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       frame_valid,
    input logic [7:0] frame_opcode,
    input logic       wp_n,
    input logic       cmd_ok,
    input logic       cmd_bad,
    input logic       deep_pd,
    input logic [7:0] status_o
);
    // R11
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ok && cmd_bad));

    // R11
    resp_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> (cmd_ok || cmd_bad));

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok || cmd_bad) |-> $past(frame_valid));

    // R2
    need_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && is_modify(frame_opcode) && !status_o[1]) |=> cmd_bad);

    // R3
    wel_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> !status_o[1]);

    // R6
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_opcode == OP_WRSR && status_o[7] && !wp_n) |=> cmd_bad);

    // R7
    deep_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_pd && frame_valid && frame_opcode != OP_RES) |=> (cmd_bad && deep_pd && $stable(status_o)));

    // R9
    busy_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && frame_valid && frame_opcode != OP_RDSR) |=> cmd_bad);

endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .frame_valid(frame_valid),
    .frame_opcode(frame_opcode),
    .wp_n(wp_n),
    .cmd_ok(cmd_ok),
    .cmd_bad(cmd_bad),
    .deep_pd(deep_pd),
    .status_o(status_o)
);

// File: tb/flash_wp_ctrl_tb_top.sv
module flash_wp_ctrl_tb_top;

    localparam int ADDR_W = 18;
    localparam int CNT_W  = 12;
    localparam int NVEC   = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_valid = 1'b0;
    logic [7:0]        frame_opcode = '0;
    logic [ADDR_W-1:0] frame_addr = '0;
    logic [CNT_W-1:0]  frame_bits = '0;
    logic [7:0]        frame_data = '0;
    logic              wp_n = 1'b1;
    logic              cmd_ok, cmd_bad, deep_pd;
    logic [7:0]        status_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    flash_wp_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PUW_CYCLES(40), .BUSY_CYCLES(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .frame_opcode(frame_opcode), .frame_addr(frame_addr),
        .frame_bits(frame_bits), .frame_data(frame_data), .wp_n(wp_n),
        .cmd_ok(cmd_ok), .cmd_bad(cmd_bad), .deep_pd(deep_pd), .status_o(status_o)
    );

    // {op, addr, bits, data, wp_n, exp_ok, exp_wel_after, exp_bp_after}
    localparam logic [50:0] VEC [NVEC] = '{
        {8'h06, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b1, 2'd0}, // R1
        {8'h04, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b0, 2'd0}, // R1
        {8'h02, 18'h00000, 12'd40, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0}, // R2
        {8'h06, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b1, 2'd0},
        {8'h02, 18'h00000, 12'd41, 8'h00, 1'b1, 1'b0, 1'b1, 2'd0}, // R4
        {8'h02, 18'h00000, 12'd40, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0}, // R3
        {8'h06, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b1, 2'd0},
        {8'h01, 18'h00000, 12'd16, 8'h84, 1'b1, 1'b1, 1'b0, 2'd1}, // R6 write
        {8'h06, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b1, 2'd1},
        {8'h02, 18'h30000, 12'd40, 8'h00, 1'b1, 1'b0, 1'b1, 2'd1}, // R5
        {8'hD8, 18'h20000, 12'd32, 8'h00, 1'b1, 1'b1, 1'b0, 2'd1}, // R5
        {8'h06, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b1, 2'd1},
        {8'hC7, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b0, 1'b1, 2'd1}, // R5
        {8'h01, 18'h00000, 12'd16, 8'h00, 1'b0, 1'b0, 1'b1, 2'd1}, // R6
        {8'h01, 18'h00000, 12'd16, 8'h88, 1'b1, 1'b1, 1'b0, 2'd2}, // R6
        {8'h06, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b1, 2'd2},
        {8'hD8, 18'h20000, 12'd32, 8'h00, 1'b1, 1'b0, 1'b1, 2'd2}, // R5
        {8'hD8, 18'h10000, 12'd32, 8'h00, 1'b1, 1'b1, 1'b0, 2'd2}, // R5
        {8'h55, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b0, 1'b0, 2'd2}, // R11
        {8'h06, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b1, 2'd2},
        {8'h01, 18'h00000, 12'd16, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0}, // R6
        {8'h06, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b1, 2'd0},
        {8'hC7, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b0, 2'd0}, // R5
        {8'h05, 18'h00000, 12'd8,  8'h00, 1'b1, 1'b1, 1'b0, 2'd0}
    };

    task automatic check(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [ADDR_W-1:0] a,
                        input logic [CNT_W-1:0] n, input logic [7:0] d, input logic w);
        @(negedge clk);
        frame_opcode = op; frame_addr = a; frame_bits = n; frame_data = d; wp_n = w;
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 60 && status_o[0]; k++) @(negedge clk);
    endtask

    task automatic expect_resp(input bit ok, input string req);
        check(cmd_ok == ok && cmd_bad == !ok, req, {cmd_ok, cmd_bad}, {ok, !ok});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(status_o == 8'h00, "R10 status", status_o, 8'h00);
        check(!cmd_ok && !cmd_bad && !deep_pd, "R10 pulses", {cmd_ok, cmd_bad, deep_pd}, 0);
        rst_n = 1'b1;

        // R8 power-up wait
        send(8'h06, '0, 12'd8, 8'h00, 1'b1);
        expect_resp(1'b1, "R1 wren in powerup");
        send(8'h02, '0, 12'd40, 8'h00, 1'b1);
        expect_resp(1'b0, "R8 program in powerup");
        check(status_o[1:0] == 2'b10, "R8 wel kept", status_o[1:0], 2'b10);
        repeat (50) @(negedge clk);
        send(8'h04, '0, 12'd8, 8'h00, 1'b1);
        expect_resp(1'b1, "R1 wrdi");

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [50:0] v;
            v = VEC[i];
            send(v[50:43], v[42:25], v[24:13], v[12:5], v[4]);
            expect_resp(v[3], $sformatf("R11 vector %0d response", i));
            wait_idle();
            check(status_o[1] == v[2], $sformatf("R3 vector %0d wel", i), status_o[1], v[2]);
            check(status_o[3:2] == v[1:0], $sformatf("R5 vector %0d bp", i), status_o[3:2], v[1:0]);
        end

        // R9 and R3: busy window
        send(8'h06, '0, 12'd8, 8'h00, 1'b1);
        send(8'h02, 18'h00100, 12'd40, 8'h00, 1'b1);
        expect_resp(1'b1, "R3 program accepted");
        check(status_o[0] == 1'b1, "R3 wip high", status_o[0], 1);
        send(8'h06, '0, 12'd8, 8'h00, 1'b1);
        expect_resp(1'b0, "R9 wren while busy");
        send(8'h05, '0, 12'd8, 8'h00, 1'b1);
        expect_resp(1'b1, "R9 rdsr while busy");
        wait_idle();
        check(status_o[1:0] == 2'b00, "R3 done clears wel", status_o[1:0], 0);

        // R4 zero edge count
        send(8'h06, '0, 12'd8, 8'h00, 1'b1);
        send(8'hC7, '0, 12'd0, 8'h00, 1'b1);
        expect_resp(1'b0, "R4 zero count");
        check(status_o[1] == 1'b1, "R4 wel kept", status_o[1], 1);

        // R7 deep power-down
        send(8'hB9, '0, 12'd8, 8'h00, 1'b1);
        expect_resp(1'b1, "R7 enter");
        check(deep_pd == 1'b1, "R7 deep flag", deep_pd, 1);
        send(8'h04, '0, 12'd8, 8'h00, 1'b1);
        expect_resp(1'b0, "R7 wrdi ignored");
        check(status_o[1] == 1'b1, "R7 wel untouched", status_o[1], 1);
        send(8'h05, '0, 12'd8, 8'h00, 1'b1);
        expect_resp(1'b0, "R7 rdsr ignored");
        send(8'hAB, '0, 12'd8, 8'h00, 1'b1);
        expect_resp(1'b1, "R7 release");
        check(deep_pd == 1'b0, "R7 deep cleared", deep_pd, 0);

        // R11 no pulse without a frame
        @(negedge clk);
        check(!cmd_ok && !cmd_bad, "R11 idle quiet", {cmd_ok, cmd_bad}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule